// File: doc/BRIEF.md
# DMA Controller Register Interface

This block is the host-facing register file of a four-channel DMA controller that sits on an 8-bit I/O port bus. The host selects one of sixteen port offsets with a 4-bit offset, strobes a write or a read, and moves one byte at a time. Each channel holds a 16-bit address and a 16-bit count, each kept twice: a base copy that keeps the programmed value and a current copy that the transfer engine advances. Both 16-bit values are reached a byte at a time through a single low/high byte pointer that all channels share.

Around the channel registers sit the controller-wide state: command, status, request, a temporary register, a per-channel mask and a 6-bit mode field per channel. Write-only command offsets set or clear one mask bit, clear all mask bits, reset the byte pointer, or perform a master clear. The transfer engine is a separate block. It reads the programmed state from the output ports and writes back status, mask and the current address and count of one channel through a side port.

Top module: `dma_prog_port`

## Requirements
- R1: A host write to offset 2c (address) or 2c+1 (count), c = 0..3, stores the data byte into both the base and the current register of channel c: into bits 7:0 when the byte pointer is 0 and into bits 15:8 when it is 1.
- R2: A host read of offset 2c or 2c+1 returns the byte of the current (not base) address or count of channel c that the byte pointer selects; rd_data changes on the clock edge that samples rd_en and holds its value until the next read.
- R3: Every host read or write of offsets 0 to 7 flips the byte pointer; a write to offset 0xC sets it to 0, so the next access reaches bits 7:0.
- R4: A write to offset 0xB stores data bits 7:2 as the mode of the channel named by data bits 1:0; the other channels' modes do not change.
- R5: A write to offset 0xA sets mask bit n (n = data bits 1:0) when data bit 2 is 1 and clears it when data bit 2 is 0; other mask bits do not change.
- R6: A write to offset 0xF loads data bits 3:0 into the mask; a read of 0xF returns the mask in bits 3:0 with bits 7:4 zero; a write to offset 0xE clears all mask bits.
- R7: A write to offset 0xD zeroes command, status, request, the temporary register and the byte pointer and sets all four mask bits; a read of 0xD returns the temporary register.
- R8: A read of offset 8 returns the status register, a write to offset 8 loads the command register, and a write to offset 9 loads the request register.
- R9: A read of offsets 9, 0xA, 0xB, 0xC or 0xE returns 0x00 and changes no state.
- R10: After reset the mask is 0xF, command, status, request, temporary register and byte pointer are 0, and all address, count and mode registers are 0.
- R11: The engine side port loads the current address and count of the selected channel (base copies unchanged), the status register, and the mask register.
- R12: When a host write and an engine update reach the same register in one cycle, the host write decides its value: a mask command beats an engine mask load, a master clear beats an engine status load, and a host byte write to a channel's current address or count drops the engine value for that register while the other register of the channel still takes the engine value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ofs | input | 4 | Host port offset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| wr_data | input | 8 | Host write byte |
| rd_data | output | 8 | Host read byte, registered |
| eng_cur_we | input | 1 | Engine loads current address and count of eng_chan |
| eng_chan | input | 2 | Channel targeted by the engine update |
| eng_addr | input | 16 | New current address |
| eng_cnt | input | 16 | New current count |
| eng_stat_we | input | 1 | Engine loads the status register |
| eng_stat | input | 8 | New status value |
| eng_mask_we | input | 1 | Engine loads the mask register |
| eng_mask | input | 4 | New mask value |
| base_addr_o | output | 64 | Base addresses, channel c at bits 16c+15:16c |
| cur_addr_o | output | 64 | Current addresses, same packing |
| base_cnt_o | output | 64 | Base counts, same packing |
| cur_cnt_o | output | 64 | Current counts, same packing |
| mode_o | output | 24 | Modes, channel c at bits 6c+5:6c |
| cmd_o | output | 8 | Command register |
| req_o | output | 8 | Request register |
| mask_o | output | 4 | Mask register, bit c for channel c |

## Verification
The functions that can land in one cycle are a host register write and an engine side-port update aimed at the same register: mask commands against an engine mask load, master clear against an engine status load, and a host address byte against an engine current-address load on the same channel. The bench drives both in the same clock period and then checks through the outputs and read-back that the host value won, while the untouched count of that channel still took the engine value. A second overlap, the shared byte pointer moved by accesses to different channels, is judged by interleaving channels and confirming which byte each access reached.

// File: rtl/dmr_pkg.sv
package dmr_pkg;

   localparam int unsigned OFS_W = 4;

   typedef enum logic [OFS_W-1:0] {
      OFS_STAT_CMD = 4'h8,
      OFS_REQUEST  = 4'h9,
      OFS_MASK_ONE = 4'hA,
      OFS_MODE     = 4'hB,
      OFS_PTR_CLR  = 4'hC,
      OFS_MCLR_TMP = 4'hD,
      OFS_MASK_CLR = 4'hE,
      OFS_MASK_ALL = 4'hF
   } ctl_ofs_e;

   typedef struct packed {
      logic stat_cmd;
      logic request;
      logic mask_one;
      logic mode;
      logic ptr_clr;
      logic mclr_tmp;
      logic mask_clr;
      logic mask_all;
   } ctl_hit_t;

endpackage

// File: rtl/dmr_decode.sv
module dmr_decode
   import dmr_pkg::*;
#(
   parameter int unsigned NUM_CH = 4,
   localparam int unsigned CH_W  = $clog2(NUM_CH)
) (
   input  logic [OFS_W-1:0] ofs,
   input  logic             wr_en,
   input  logic             rd_en,
   output logic [NUM_CH-1:0] wr_addr,
   output logic [NUM_CH-1:0] wr_cnt,
   output logic             chan_acc,
   output ctl_hit_t         ctl_wr,
   output ctl_hit_t         ctl_rd
);

   logic            is_chan;
   logic [CH_W-1:0] chan_idx;

   assign is_chan  = ~ofs[OFS_W-1];
   assign chan_idx = ofs[CH_W:1];
   assign chan_acc = is_chan & (wr_en | rd_en);

   for (genvar c = 0; c < NUM_CH; c++) begin : g_chan_dec
      logic hit;
      assign hit        = wr_en & is_chan & (chan_idx == CH_W'(c));
      assign wr_addr[c] = hit & ~ofs[0];
      assign wr_cnt[c]  = hit &  ofs[0];
   end

   function automatic ctl_hit_t hits(input logic [OFS_W-1:0] o, input logic en);
      ctl_hit_t h;
      h.stat_cmd = en & (o == OFS_STAT_CMD);
      h.request  = en & (o == OFS_REQUEST);
      h.mask_one = en & (o == OFS_MASK_ONE);
      h.mode     = en & (o == OFS_MODE);
      h.ptr_clr  = en & (o == OFS_PTR_CLR);
      h.mclr_tmp = en & (o == OFS_MCLR_TMP);
      h.mask_clr = en & (o == OFS_MASK_CLR);
      h.mask_all = en & (o == OFS_MASK_ALL);
      return h;
   endfunction

   assign ctl_wr = hits(ofs, wr_en);
   assign ctl_rd = hits(ofs, rd_en);

endmodule

// File: rtl/dmr_chan.sv
module dmr_chan #(
   parameter int unsigned AW = 16,
   parameter int unsigned DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ptr,
   input  logic          wr_addr,
   input  logic          wr_cnt,
   input  logic [DW-1:0] wr_data,
   input  logic          eng_we,
   input  logic [AW-1:0] eng_addr,
   input  logic [AW-1:0] eng_cnt,
   output logic [AW-1:0] base_addr,
   output logic [AW-1:0] cur_addr,
   output logic [AW-1:0] base_cnt,
   output logic [AW-1:0] cur_cnt
);

   function automatic logic [AW-1:0] put_byte(input logic [AW-1:0] old,
                                              input logic          sel,
                                              input logic [DW-1:0] b);
      logic [AW-1:0] r;
      r = old;
      r[int'(sel)*DW +: DW] = b;
      return r;
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_addr <= '0;
         cur_addr  <= '0;
      end else if (wr_addr) begin
         base_addr <= put_byte(base_addr, ptr, wr_data);
         cur_addr  <= put_byte(cur_addr, ptr, wr_data);
      end else if (eng_we) begin
         cur_addr  <= eng_addr;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_cnt <= '0;
         cur_cnt  <= '0;
      end else if (wr_cnt) begin
         base_cnt <= put_byte(base_cnt, ptr, wr_data);
         cur_cnt  <= put_byte(cur_cnt, ptr, wr_data);
      end else if (eng_we) begin
         cur_cnt   <= eng_cnt;
      end
   end

endmodule

// File: rtl/dmr_ctrl.sv
module dmr_ctrl
   import dmr_pkg::*;
#(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned DW     = 8,
   localparam int unsigned CH_W   = $clog2(NUM_CH),
   localparam int unsigned MODE_W = DW - CH_W
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  ctl_hit_t                 ctl_wr,
   input  logic                     chan_acc,
   input  logic [DW-1:0]            wr_data,
   input  logic                     eng_stat_we,
   input  logic [DW-1:0]            eng_stat,
   input  logic                     eng_mask_we,
   input  logic [NUM_CH-1:0]        eng_mask,
   output logic                     ptr,
   output logic [DW-1:0]            cmd,
   output logic [DW-1:0]            status,
   output logic [DW-1:0]            request,
   output logic [DW-1:0]            temp,
   output logic [NUM_CH-1:0]        mask,
   output logic [NUM_CH*MODE_W-1:0] modes
);

   logic [CH_W-1:0] sel_ch;
   assign sel_ch = wr_data[CH_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n || ctl_wr.mclr_tmp) begin
         ptr     <= 1'b0;
         cmd     <= '0;
         status  <= '0;
         request <= '0;
         temp    <= '0;
      end else begin
         if (ctl_wr.ptr_clr)       ptr     <= 1'b0;
         else if (chan_acc)        ptr     <= ~ptr;
         if (ctl_wr.stat_cmd)      cmd     <= wr_data;
         if (ctl_wr.request)       request <= wr_data;
         if (eng_stat_we)          status  <= eng_stat;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || ctl_wr.mclr_tmp) begin
         mask <= '1;
      end else if (ctl_wr.mask_all) begin
         mask <= wr_data[NUM_CH-1:0];
      end else if (ctl_wr.mask_clr) begin
         mask <= '0;
      end else if (ctl_wr.mask_one) begin
         mask[sel_ch] <= wr_data[CH_W];
      end else if (eng_mask_we) begin
         mask <= eng_mask;
      end
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_mode
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            modes[c*MODE_W +: MODE_W] <= '0;
         end else if (ctl_wr.mode && sel_ch == CH_W'(c)) begin
            modes[c*MODE_W +: MODE_W] <= wr_data[DW-1:CH_W];
         end
      end
   end

endmodule

// File: rtl/dmr_rdmux.sv
module dmr_rdmux
   import dmr_pkg::*;
#(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned AW     = 16,
   parameter int unsigned DW     = 8,
   localparam int unsigned CH_W  = $clog2(NUM_CH)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [OFS_W-1:0]     ofs,
   input  logic                 rd_en,
   input  ctl_hit_t             ctl_rd,
   input  logic                 ptr,
   input  logic [NUM_CH*AW-1:0] cur_addr,
   input  logic [NUM_CH*AW-1:0] cur_cnt,
   input  logic [DW-1:0]        status,
   input  logic [DW-1:0]        temp,
   input  logic [NUM_CH-1:0]    mask,
   output logic [DW-1:0]        rd_data
);

   logic [CH_W-1:0] ch;
   logic [AW-1:0]   word;
   logic [DW-1:0]   nxt;

   assign ch   = ofs[CH_W:1];
   assign word = ofs[0] ? cur_cnt[int'(ch)*AW +: AW] : cur_addr[int'(ch)*AW +: AW];

   always_comb begin
      nxt = '0;
      if (!ofs[OFS_W-1])         nxt = word[int'(ptr)*DW +: DW];
      else if (ctl_rd.stat_cmd)  nxt = status;
      else if (ctl_rd.mclr_tmp)  nxt = temp;
      else if (ctl_rd.mask_all)  nxt = DW'(mask);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     rd_data <= '0;
      else if (rd_en) rd_data <= nxt;
   end

endmodule

// File: rtl/dma_prog_port.sv
module dma_prog_port
   import dmr_pkg::*;
#(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned AW     = 16,
   parameter int unsigned DW     = 8,
   localparam int unsigned CH_W   = $clog2(NUM_CH),
   localparam int unsigned MODE_W = DW - CH_W
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [3:0]               ofs,
   input  logic                     wr_en,
   input  logic                     rd_en,
   input  logic [DW-1:0]            wr_data,
   output logic [DW-1:0]            rd_data,
   input  logic                     eng_cur_we,
   input  logic [CH_W-1:0]          eng_chan,
   input  logic [AW-1:0]            eng_addr,
   input  logic [AW-1:0]            eng_cnt,
   input  logic                     eng_stat_we,
   input  logic [DW-1:0]            eng_stat,
   input  logic                     eng_mask_we,
   input  logic [NUM_CH-1:0]        eng_mask,
   output logic [NUM_CH*AW-1:0]     base_addr_o,
   output logic [NUM_CH*AW-1:0]     cur_addr_o,
   output logic [NUM_CH*AW-1:0]     base_cnt_o,
   output logic [NUM_CH*AW-1:0]     cur_cnt_o,
   output logic [NUM_CH*MODE_W-1:0] mode_o,
   output logic [DW-1:0]            cmd_o,
   output logic [DW-1:0]            req_o,
   output logic [NUM_CH-1:0]        mask_o
);

   if (NUM_CH != 4) begin : g_bad_ch
      $error("dma_prog_port: offset map needs NUM_CH == 4");
   end
   if (AW != 2 * DW) begin : g_bad_aw
      $error("dma_prog_port: one pointer bit needs AW == 2*DW");
   end

   logic [NUM_CH-1:0] wr_addr, wr_cnt;
   logic              chan_acc;
   ctl_hit_t          ctl_wr, ctl_rd;
   logic              ptr_q;
   logic [DW-1:0]     status_q, temp_q;

   dmr_decode #(.NUM_CH(NUM_CH)) u_dec (
      .ofs(ofs), .wr_en(wr_en), .rd_en(rd_en),
      .wr_addr(wr_addr), .wr_cnt(wr_cnt), .chan_acc(chan_acc),
      .ctl_wr(ctl_wr), .ctl_rd(ctl_rd)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic eng_hit;
      assign eng_hit = eng_cur_we & (eng_chan == CH_W'(c));
      dmr_chan #(.AW(AW), .DW(DW)) u_chan (
         .clk(clk), .rst_n(rst_n), .ptr(ptr_q),
         .wr_addr(wr_addr[c]), .wr_cnt(wr_cnt[c]), .wr_data(wr_data),
         .eng_we(eng_hit), .eng_addr(eng_addr), .eng_cnt(eng_cnt),
         .base_addr(base_addr_o[c*AW +: AW]), .cur_addr(cur_addr_o[c*AW +: AW]),
         .base_cnt(base_cnt_o[c*AW +: AW]),   .cur_cnt(cur_cnt_o[c*AW +: AW])
      );
   end

   dmr_ctrl #(.NUM_CH(NUM_CH), .DW(DW)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .chan_acc(chan_acc),
      .wr_data(wr_data),
      .eng_stat_we(eng_stat_we), .eng_stat(eng_stat),
      .eng_mask_we(eng_mask_we), .eng_mask(eng_mask),
      .ptr(ptr_q), .cmd(cmd_o), .status(status_q), .request(req_o),
      .temp(temp_q), .mask(mask_o), .modes(mode_o)
   );

   dmr_rdmux #(.NUM_CH(NUM_CH), .AW(AW), .DW(DW)) u_rd (
      .clk(clk), .rst_n(rst_n), .ofs(ofs), .rd_en(rd_en), .ctl_rd(ctl_rd),
      .ptr(ptr_q), .cur_addr(cur_addr_o), .cur_cnt(cur_cnt_o),
      .status(status_q), .temp(temp_q), .mask(mask_o), .rd_data(rd_data)
   );

endmodule

// File: rtl/dmr_checker.sv
module dmr_checker #(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned AW     = 16,
   parameter int unsigned DW     = 8
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [3:0]           ofs,
   input logic                 wr_en,
   input logic                 rd_en,
   input logic [DW-1:0]        wr_data,
   input logic [DW-1:0]        rd_data,
   input logic                 ptr_q,
   input logic [NUM_CH*AW-1:0] base_addr_o,
   input logic [NUM_CH*AW-1:0] cur_addr_o,
   input logic [DW-1:0]        cmd_o,
   input logic [DW-1:0]        req_o,
   input logic [NUM_CH-1:0]    mask_o
);

   // R1: low-byte write of channel 0 address lands in both copies
   assert_dual_copy_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && ofs == 4'h0 && !ptr_q) |=>
         (cur_addr_o[DW-1:0] == $past(wr_data) && base_addr_o[DW-1:0] == $past(wr_data)));

   // R3: any channel-register access flips the pointer
   assert_ptr_flip_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ((wr_en || rd_en) && !ofs[3]) |=> (ptr_q != $past(ptr_q)));

   // R3: pointer clear command
   assert_ptr_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && ofs == 4'hC) |=> !ptr_q);

   // R5: single-bit mask set
   assert_mask_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && ofs == 4'hA && wr_data[2]) |=> mask_o[$past(wr_data[1:0])]);

   // R7: master clear
   assert_master_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && ofs == 4'hD) |=>
         (&mask_o && cmd_o == '0 && req_o == '0 && !ptr_q));

   // R9: write-only offsets read as zero
   assert_wo_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && (ofs == 4'h9 || ofs == 4'hA || ofs == 4'hB || ofs == 4'hC || ofs == 4'hE))
         |=> (rd_data == '0));

   // R12: clear-mask command wins over any engine mask load
   assert_host_mask_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && ofs == 4'hE) |=> (mask_o == '0));

endmodule

bind dma_prog_port dmr_checker #(.NUM_CH(NUM_CH), .AW(AW), .DW(DW)) u_chk (
   .clk(clk), .rst_n(rst_n), .ofs(ofs), .wr_en(wr_en), .rd_en(rd_en),
   .wr_data(wr_data), .rd_data(rd_data), .ptr_q(ptr_q),
   .base_addr_o(base_addr_o), .cur_addr_o(cur_addr_o),
   .cmd_o(cmd_o), .req_o(req_o), .mask_o(mask_o)
);

// File: tb/dma_prog_port_test.sv
module dma_prog_port_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  ofs = '0;
   logic        wr_en = 1'b0, rd_en = 1'b0;
   logic [7:0]  wr_data = '0;
   logic [7:0]  rd_data;
   logic        eng_cur_we = 1'b0;
   logic [1:0]  eng_chan = '0;
   logic [15:0] eng_addr = '0, eng_cnt = '0;
   logic        eng_stat_we = 1'b0;
   logic [7:0]  eng_stat = '0;
   logic        eng_mask_we = 1'b0;
   logic [3:0]  eng_mask = '0;
   logic [63:0] base_addr_o, cur_addr_o, base_cnt_o, cur_cnt_o;
   logic [23:0] mode_o;
   logic [7:0]  cmd_o, req_o;
   logic [3:0]  mask_o;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   dma_prog_port uut (
      .clk(clk), .rst_n(rst_n), .ofs(ofs), .wr_en(wr_en), .rd_en(rd_en),
      .wr_data(wr_data), .rd_data(rd_data),
      .eng_cur_we(eng_cur_we), .eng_chan(eng_chan), .eng_addr(eng_addr), .eng_cnt(eng_cnt),
      .eng_stat_we(eng_stat_we), .eng_stat(eng_stat),
      .eng_mask_we(eng_mask_we), .eng_mask(eng_mask),
      .base_addr_o(base_addr_o), .cur_addr_o(cur_addr_o),
      .base_cnt_o(base_cnt_o), .cur_cnt_o(cur_cnt_o),
      .mode_o(mode_o), .cmd_o(cmd_o), .req_o(req_o), .mask_o(mask_o)
   );

   typedef struct packed {
      logic       rd;
      logic [3:0] o;
      logic [7:0] d;     // write data, or expected read data
      logic [3:0] rq;    // requirement number reported on failure
   } vec_t;

   localparam int NV = 28;
   localparam vec_t VEC [NV] = '{
      '{1'b1, 4'h8, 8'h00, 4'd10},  // R10 status zero after reset
      '{1'b1, 4'hF, 8'h0F, 4'd10},  // R10 mask all set after reset
      '{1'b0, 4'h0, 8'h34, 4'd1},   // R1 ch0 addr low
      '{1'b0, 4'h0, 8'h12, 4'd1},   // R1 ch0 addr high
      '{1'b1, 4'h0, 8'h34, 4'd2},   // R2 read low
      '{1'b1, 4'h0, 8'h12, 4'd2},   // R2 read high
      '{1'b0, 4'h3, 8'hCD, 4'd1},   // R1 ch1 count low
      '{1'b0, 4'h3, 8'hAB, 4'd1},   // R1 ch1 count high
      '{1'b1, 4'h3, 8'hCD, 4'd2},
      '{1'b1, 4'h3, 8'hAB, 4'd2},
      '{1'b0, 4'h0, 8'h55, 4'd3},   // R3 pointer now 1
      '{1'b0, 4'hC, 8'h00, 4'd3},   // R3 pointer clear
      '{1'b0, 4'h2, 8'h66, 4'd3},   // lands in low byte
      '{1'b0, 4'h2, 8'h77, 4'd3},
      '{1'b1, 4'h2, 8'h66, 4'd3},
      '{1'b1, 4'h0, 8'h12, 4'd3},   // shared pointer: high byte of ch0
      '{1'b0, 4'hE, 8'h00, 4'd6},   // R6 clear all
      '{1'b1, 4'hF, 8'h00, 4'd6},
      '{1'b0, 4'hA, 8'h06, 4'd5},   // R5 set ch2
      '{1'b0, 4'hA, 8'h05, 4'd5},   // R5 set ch1
      '{1'b1, 4'hF, 8'h06, 4'd5},
      '{1'b0, 4'hA, 8'h02, 4'd5},   // R5 clear ch2
      '{1'b1, 4'hF, 8'h02, 4'd5},
      '{1'b0, 4'hF, 8'hF9, 4'd6},   // R6 load bits 3:0
      '{1'b1, 4'hF, 8'h09, 4'd6},
      '{1'b0, 4'h8, 8'h44, 4'd8},   // R8 command write
      '{1'b1, 4'h8, 8'h00, 4'd8},   // R8 reads status, not command
      '{1'b1, 4'hD, 8'h00, 4'd7}    // R7 temp read
   };

   task automatic check(input int rq, input string what, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL R%0d %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
      end
   endtask

   task automatic host_wr(input logic [3:0] o, input logic [7:0] d);
      @(negedge clk);
      ofs = o; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic host_rd(input logic [3:0] o, output logic [7:0] d);
      @(negedge clk);
      ofs = o; rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      d = rd_data;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] r;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R10 reset state at the ports
      check(10, "mask after reset", 64'(mask_o), 64'hF);
      check(10, "cmd after reset", 64'(cmd_o), 64'h0);
      check(10, "req after reset", 64'(req_o), 64'h0);
      check(10, "addr after reset", cur_addr_o | base_addr_o, 64'h0);
      check(10, "mode after reset", 64'(mode_o), 64'h0);

      for (int i = 0; i < NV; i++) begin
         if (VEC[i].rd) begin
            host_rd(VEC[i].o, r);
            check(int'(VEC[i].rq), $sformatf("vector %0d read ofs %0h", i, VEC[i].o), 64'(r), 64'(VEC[i].d));
         end else begin
            host_wr(VEC[i].o, VEC[i].d);
         end
      end
      check(8, "command register", 64'(cmd_o), 64'h44);
      check(1, "ch0 base addr", 64'(base_addr_o[15:0]), 64'h1255);
      check(1, "ch1 base cnt", 64'(base_cnt_o[31:16]), 64'hABCD);

      // R9 write-only offsets read zero, and the read leaves pointer alone
      host_wr(4'hC, 8'h00);
      foreach (VEC[i]) begin end
      host_rd(4'h9, r); check(9, "read ofs 9", 64'(r), 64'h0);
      host_rd(4'hB, r); check(9, "read ofs B", 64'(r), 64'h0);
      host_rd(4'hC, r); check(9, "read ofs C", 64'(r), 64'h0);
      host_rd(4'hE, r); check(9, "read ofs E", 64'(r), 64'h0);
      host_rd(4'hA, r); check(9, "read ofs A", 64'(r), 64'h0);
      host_rd(4'h0, r); check(9, "pointer untouched by reads", 64'(r), 64'h55);
      check(9, "mask untouched by reads", 64'(mask_o), 64'h9);

      // R4 mode write for channel 2 only
      host_wr(4'hB, 8'hA6);
      check(4, "ch2 mode", 64'(mode_o[17:12]), 64'h29);
      check(4, "other modes", 64'({mode_o[23:18], mode_o[11:0]}), 64'h0);

      // R8 request register
      host_wr(4'h9, 8'h05);
      check(8, "request register", 64'(req_o), 64'h05);

      // R11 engine updates
      @(negedge clk);
      eng_cur_we = 1'b1; eng_chan = 2'd1; eng_addr = 16'h1000; eng_cnt = 16'h0020;
      eng_stat_we = 1'b1; eng_stat = 8'h21;
      eng_mask_we = 1'b1; eng_mask = 4'h3;
      @(negedge clk);
      eng_cur_we = 1'b0; eng_stat_we = 1'b0; eng_mask_we = 1'b0;
      check(11, "ch1 cur addr", 64'(cur_addr_o[31:16]), 64'h1000);
      check(11, "ch1 base addr kept", 64'(base_addr_o[31:16]), 64'h7766);
      check(11, "ch1 cur cnt", 64'(cur_cnt_o[31:16]), 64'h0020);
      check(11, "mask", 64'(mask_o), 64'h3);
      host_rd(4'h8, r); check(11, "status read", 64'(r), 64'h21);
      host_wr(4'hC, 8'h00);
      host_rd(4'h2, r); check(2, "current not base low", 64'(r), 64'h00);
      host_rd(4'h2, r); check(2, "current not base high", 64'(r), 64'h10);

      // R12 host byte write vs engine load on the same channel
      @(negedge clk);
      ofs = 4'h2; wr_data = 8'h99; wr_en = 1'b1;
      eng_cur_we = 1'b1; eng_chan = 2'd1; eng_addr = 16'h4444; eng_cnt = 16'h0100;
      @(negedge clk);
      wr_en = 1'b0; eng_cur_we = 1'b0;
      check(12, "ch1 cur addr host wins", 64'(cur_addr_o[31:16]), 64'h1099);
      check(12, "ch1 base addr", 64'(base_addr_o[31:16]), 64'h7799);
      check(12, "ch1 cur cnt engine applies", 64'(cur_cnt_o[31:16]), 64'h0100);

      // R12 mask command vs engine mask
      @(negedge clk);
      ofs = 4'hE; wr_en = 1'b1; eng_mask_we = 1'b1; eng_mask = 4'hF;
      @(negedge clk);
      wr_en = 1'b0; eng_mask_we = 1'b0;
      check(12, "clear mask beats engine", 64'(mask_o), 64'h0);

      // R7 master clear, colliding with engine status (R12)
      host_wr(4'hC, 8'h00);
      host_wr(4'h0, 8'h11);           // pointer now 1
      @(negedge clk);
      ofs = 4'hD; wr_data = 8'h00; wr_en = 1'b1; eng_stat_we = 1'b1; eng_stat = 8'hFF;
      @(negedge clk);
      wr_en = 1'b0; eng_stat_we = 1'b0;
      check(7, "mask after master clear", 64'(mask_o), 64'hF);
      check(7, "cmd after master clear", 64'(cmd_o), 64'h0);
      check(7, "req after master clear", 64'(req_o), 64'h0);
      host_rd(4'h8, r); check(12, "status cleared despite engine", 64'(r), 64'h0);
      host_rd(4'hD, r); check(7, "temp read", 64'(r), 64'h0);
      host_wr(4'hC, 8'h00);
      host_wr(4'hD, 8'h00);
      host_wr(4'h0, 8'hEE);
      check(7, "pointer zero after master clear", 64'(cur_addr_o[15:0]), 64'h12EE);
      check(7, "modes kept by master clear", 64'(mode_o[17:12]), 64'h29);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule